// File: doc/BRIEF.md
# Serial-wire debug connect sequencer

This block is the host-side part of a debug probe that moves a target's combined JTAG/serial-wire debug port from one wire protocol to the other. A one-cycle connect strobe makes it clock out a line reset, the 16-bit code that selects serial-wire operation, a second line reset and eight low idle bits. It then hands an ID-register read request to an external transfer engine. When the engine returns the acknowledge, the sequencer clocks eight more low idle bits and reports that acknowledge as the connect status.

A disconnect strobe clocks a line reset followed by the code that selects JTAG operation, and then finishes without any ID read. The block generates the debug clock from the system clock. Each bit occupies one clock period: the clock is low for `HALF_CYC` system cycles and then high for `HALF_CYC` system cycles. Data changes only while the clock is low, so the target samples it on the rising edge. Outside a sequence, the clock rests low and the data line rests high.

Top module: `swd_conn_seq`

## Requirements
- R1: While idle, and after reset, `swclk_o` is 0, `swdio_o` is 1, and `busy_o`, `done_o` and `xfer_req_o` are 0. An asynchronous reset in the middle of a sequence returns the block to this state.
- R2: Every sequence begins with a line reset of `RST_CLKS` bits with data 1. `RST_CLKS` is at least 50 and defaults to 50. The clock is low in the first busy cycle.
- R3: A connect sequence sends byte 0x9E and then byte 0xE7, each least significant bit first, right after the first line reset.
- R4: A disconnect sequence sends byte 0x3C and then byte 0xE7, least significant bit first, after the line reset. It then finishes with no ID-read request and with `status_o` = 3'b001. A disconnect sequence is 16 + `RST_CLKS` bits in total.
- R5: After the connect code, a second line reset of `RST_CLKS` one-bits is followed by 8 bits with data 0.
- R6: After those 8 bits, `xfer_req_o` rises with `xfer_hdr_o` = 8'hA5. This is the ID-register read header, sent least significant bit first. `xfer_req_o` stays high until a cycle with `xfer_ack_valid_i` = 1. While it is high, `swclk_o` is 0 and `swdio_o` is 1.
- R7: The acknowledge `xfer_ack_i` sampled with `xfer_ack_valid_i` becomes `status_o` of a connect sequence. The handshake is followed by 8 bits with data 0 before the sequence finishes.
- R8: `busy_o` is high from the cycle after the accepted strobe until the sequence finishes. `done_o` is a single-cycle pulse in the first cycle after `busy_o` falls.
- R9: Strobes that arrive while `busy_o` is high are ignored. If both strobes are asserted together while idle, the connect sequence is performed.
- R10: Each bit lasts 2·`HALF_CYC` system cycles, with the clock low for the first half. `swdio_o` is stable while `swclk_o` is high. A disconnect keeps `busy_o` high for exactly (16 + `RST_CLKS`)·2·`HALF_CYC` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| connect_i | input | 1 | Strobe: start the switch to serial-wire mode |
| disconnect_i | input | 1 | Strobe: start the switch back to JTAG |
| xfer_ack_valid_i | input | 1 | Transfer engine has finished the ID read |
| xfer_ack_i | input | 3 | Acknowledge code returned by the transfer engine |
| swclk_o | output | 1 | Debug clock level |
| swdio_o | output | 1 | Host data line level |
| xfer_req_o | output | 1 | Request to the transfer engine for the ID read |
| xfer_hdr_o | output | 8 | Request header for the transfer engine |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when a sequence finishes |
| status_o | output | 3 | Acknowledge of the last connect, or 3'b001 after a disconnect |

## Verification
The assertions check the following on every cycle: the resting pin levels while idle; the clock and data levels at the first busy cycle; data stability while the clock is high; that the request is held until the acknowledge arrives, with the clock parked low during the wait; and that `done_o` is a one-cycle pulse that follows a busy period. Only the bench scenarios can show the following: that the recorded bit stream matches the exact reset, code and idle segments for both directions; that the acknowledge value lands in `status_o`; the total cycle count of a sequence; and that strobes during a sequence, or both strobes at once, do not change the sequence that runs.

// File: rtl/swd_conn_pkg.sv
package swd_conn_pkg;
  typedef enum logic [2:0] {
    PH_OFF, PH_RST1, PH_CODE, PH_RST2, PH_IDLE1, PH_READ, PH_IDLE2
  } phase_e;

  // switch codes, bit 0 goes out first
  localparam logic [15:0] CODE_TO_SW   = 16'hE79E;
  localparam logic [15:0] CODE_TO_JTAG = 16'hE73C;
  // ID read: start=1 apndp=0 rnw=1 a2=0 a3=0 par=1 stop=0 park=1, LSB first
  localparam logic [7:0]  ID_RD_HDR    = 8'hA5;
  localparam logic [2:0]  ACK_OK       = 3'b001;
  localparam int          IDLE_BITS    = 8;
  localparam int          CODE_BITS    = 16;
endpackage

// File: rtl/swd_conn_clkdiv.sv
module swd_conn_clkdiv #(
  parameter int HALF_CYC = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic swclk_o,
  output logic slot_end_o
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(2 * HALF_CYC) : 1;
  localparam logic [CW-1:0] TOP  = CW'(2 * HALF_CYC - 1);
  localparam logic [CW-1:0] HALF = CW'(HALF_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!en_i)        cnt_q <= '0;
    else if (cnt_q == TOP) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign swclk_o    = en_i && (cnt_q >= HALF);
  assign slot_end_o = en_i && (cnt_q == TOP);
endmodule

// File: rtl/swd_conn_bitsrc.sv
module swd_conn_bitsrc
  import swd_conn_pkg::*;
(
  input  phase_e     phase_i,
  input  logic [3:0] code_idx_i,
  input  logic       to_sw_i,
  output logic       bit_o
);
  logic [15:0] code;
  assign code = to_sw_i ? CODE_TO_SW : CODE_TO_JTAG;

  always_comb begin
    unique case (phase_i)
      PH_RST1, PH_RST2:   bit_o = 1'b1;
      PH_CODE:            bit_o = code[code_idx_i];
      PH_IDLE1, PH_IDLE2: bit_o = 1'b0;
      default:            bit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/swd_conn_seq.sv
module swd_conn_seq
  import swd_conn_pkg::*;
#(
  parameter int RST_CLKS = 50,
  parameter int HALF_CYC = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       connect_i,
  input  logic       disconnect_i,
  input  logic       xfer_ack_valid_i,
  input  logic [2:0] xfer_ack_i,
  output logic       swclk_o,
  output logic       swdio_o,
  output logic       xfer_req_o,
  output logic [7:0] xfer_hdr_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [2:0] status_o
);
  localparam int BIT_W = $clog2(RST_CLKS);
  localparam logic [BIT_W-1:0] LAST_RST  = BIT_W'(RST_CLKS - 1);
  localparam logic [BIT_W-1:0] LAST_CODE = BIT_W'(CODE_BITS - 1);
  localparam logic [BIT_W-1:0] LAST_IDLE = BIT_W'(IDLE_BITS - 1);

  phase_e           phase_q, phase_nx;
  logic [BIT_W-1:0] bit_q, last_idx;
  logic             to_sw_q, done_q;
  logic [2:0]       status_q;
  logic             clk_en, slot_end, data_bit;

  assign clk_en = (phase_q != PH_OFF) && (phase_q != PH_READ);

  swd_conn_clkdiv #(.HALF_CYC(HALF_CYC)) u_clkdiv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (clk_en),
    .swclk_o    (swclk_o),
    .slot_end_o (slot_end)
  );

  swd_conn_bitsrc u_bitsrc (
    .phase_i    (phase_q),
    .code_idx_i (bit_q[3:0]),
    .to_sw_i    (to_sw_q),
    .bit_o      (data_bit)
  );

  always_comb begin
    unique case (phase_q)
      PH_RST1, PH_RST2: last_idx = LAST_RST;
      PH_CODE:          last_idx = LAST_CODE;
      default:          last_idx = LAST_IDLE;
    endcase
  end

  always_comb begin
    unique case (phase_q)
      PH_RST1:  phase_nx = PH_CODE;
      PH_CODE:  phase_nx = to_sw_q ? PH_RST2 : PH_OFF;
      PH_RST2:  phase_nx = PH_IDLE1;
      PH_IDLE1: phase_nx = PH_READ;
      default:  phase_nx = PH_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_OFF;
      bit_q    <= '0;
      to_sw_q  <= 1'b0;
      done_q   <= 1'b0;
      status_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_OFF: if (connect_i || disconnect_i) begin
          to_sw_q <= connect_i;  // connect wins a tie
          bit_q   <= '0;
          phase_q <= PH_RST1;
        end
        PH_READ: if (xfer_ack_valid_i) begin
          status_q <= xfer_ack_i;
          phase_q  <= PH_IDLE2;
        end
        default: if (slot_end) begin
          if (bit_q == last_idx) begin
            bit_q   <= '0;
            phase_q <= phase_nx;
            if (phase_nx == PH_OFF) done_q <= 1'b1;
            if (phase_q == PH_CODE && !to_sw_q) status_q <= ACK_OK;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign swdio_o    = data_bit;
  assign xfer_req_o = (phase_q == PH_READ);
  assign xfer_hdr_o = ID_RD_HDR;
  assign busy_o     = (phase_q != PH_OFF);
  assign done_o     = done_q;
  assign status_o   = status_q;
endmodule

// File: rtl/swd_conn_sva.sv
module swd_conn_sva (
  input logic clk_i,
  input logic rst_ni,
  input logic swclk_o,
  input logic swdio_o,
  input logic xfer_req_o,
  input logic xfer_ack_valid_i,
  input logic busy_o,
  input logic done_o
);
  AST_IDLE_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!swclk_o && swdio_o && !xfer_req_o)); // R1
  AST_START_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (swdio_o && !swclk_o)); // R2
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_req_o && !xfer_ack_valid_i) |=> xfer_req_o); // R6
  AST_REQ_PARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o |-> (!swclk_o && swdio_o)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R8
  AST_DATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swclk_o && $past(swclk_o)) |-> $stable(swdio_o)); // R10
endmodule

bind swd_conn_seq swd_conn_sva u_sva (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .swclk_o          (swclk_o),
  .swdio_o          (swdio_o),
  .xfer_req_o       (xfer_req_o),
  .xfer_ack_valid_i (xfer_ack_valid_i),
  .busy_o           (busy_o),
  .done_o           (done_o)
);

// File: tb/swd_conn_seq_bench.sv
`timescale 1ns/1ps
module swd_conn_seq_bench;
  localparam int LRST = 50;
  localparam int HALF = 2;
  localparam logic [15:0] C_SW = 16'hE79E;
  localparam logic [15:0] C_JT = 16'hE73C;
  // scenario: {conn, ack[2:0], delay[3:0], disturb}
  localparam int NSCN = 6;
  localparam logic [8:0] SCN [NSCN] = '{
    {1'b1, 3'b001, 4'd2, 1'b0},
    {1'b1, 3'b010, 4'd5, 1'b0},
    {1'b1, 3'b100, 4'd0, 1'b0},
    {1'b1, 3'b111, 4'd1, 1'b1},
    {1'b0, 3'b000, 4'd0, 1'b0},
    {1'b0, 3'b000, 4'd3, 1'b1}
  };

  logic clk = 0, rst_ni = 0;
  logic connect_i = 0, disconnect_i = 0;
  logic xfer_ack_valid_i = 0;
  logic [2:0] xfer_ack_i = 0;
  logic swclk_o, swdio_o, xfer_req_o, busy_o, done_o;
  logic [7:0] xfer_hdr_o;
  logic [2:0] status_o;

  swd_conn_seq #(.RST_CLKS(LRST), .HALF_CYC(HALF)) u_swd_conn_seq (
    .clk_i(clk), .rst_ni(rst_ni), .connect_i(connect_i), .disconnect_i(disconnect_i),
    .xfer_ack_valid_i(xfer_ack_valid_i), .xfer_ack_i(xfer_ack_i),
    .swclk_o(swclk_o), .swdio_o(swdio_o), .xfer_req_o(xfer_req_o),
    .xfer_hdr_o(xfer_hdr_o), .busy_o(busy_o), .done_o(done_o), .status_o(status_o)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int nbits = 0, req_at = 0, done_cnt = 0, busy_cyc = 0;
  logic rec [256];
  logic prev_clk = 0, req_seen = 0, hold_bad = 0;
  logic [7:0] hdr_seen = 0;
  logic [2:0] eng_ack = 0;
  int eng_delay = 0, eng_wait = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // bit recorder, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (busy_o) busy_cyc++;
    if (swclk_o && !prev_clk && nbits < 256) begin
      rec[nbits] = swdio_o;
      nbits++;
    end
    prev_clk = swclk_o;
    if (xfer_req_o) begin
      if (!req_seen) begin
        req_seen = 1; req_at = nbits; hdr_seen = xfer_hdr_o;
      end
      if (swclk_o || !swdio_o) hold_bad = 1;
    end
    if (done_o) done_cnt++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // transfer engine model
  always @(negedge clk) begin
    xfer_ack_valid_i <= 1'b0;
    if (xfer_req_o && !xfer_ack_valid_i) begin
      if (eng_wait >= eng_delay) begin
        xfer_ack_valid_i <= 1'b1;
        xfer_ack_i <= eng_ack;
        eng_wait <= 0;
      end else eng_wait <= eng_wait + 1;
    end
  end

  function automatic logic exp_bit(input bit conn, input int i);
    if (i < LRST) return 1'b1;
    if (i < LRST + 16) return conn ? C_SW[i-LRST] : C_JT[i-LRST];
    if (i < 2*LRST + 16) return 1'b1;
    return 1'b0;
  endfunction

  // mode: 0 connect, 1 disconnect, 2 both strobes
  task automatic run(input int mode, input logic [2:0] ack, input int dly, input bit disturb);
    bit conn;
    int e2, e3, e5, e7, tot;
    conn = (mode != 1);
    nbits = 0; req_seen = 0; hold_bad = 0; done_cnt = 0; busy_cyc = 0;
    eng_ack = ack; eng_delay = dly;
    @(negedge clk);
    connect_i = (mode != 1); disconnect_i = (mode != 0);
    @(negedge clk);
    connect_i = 0; disconnect_i = 0;
    chk(busy_o == 1, "R8 busy after strobe", busy_o, 1);
    if (disturb) begin
      repeat (40) @(negedge clk);
      connect_i = 1; disconnect_i = 1;
      @(negedge clk);
      connect_i = 0; disconnect_i = 0;
    end
    while (!done_o) @(negedge clk);
    chk(status_o == (conn ? ack : 3'b001), conn ? "R7 status" : "R4 status", status_o, conn ? ack : 1);
    @(negedge clk);
    chk(!done_o && !busy_o && swdio_o && !swclk_o, "R8 done pulse and release", done_o, 0);
    chk(done_cnt == 1, "R9 one completion", done_cnt, 1);
    tot = conn ? (2*LRST + 32) : (LRST + 16);
    chk(nbits == tot, "R10 bit count", nbits, tot);
    e2 = 0; e3 = 0; e5 = 0; e7 = 0;
    for (int i = 0; i < nbits && i < tot; i++)
      if (rec[i] !== exp_bit(conn, i)) begin
        if (i < LRST) e2++;
        else if (i < LRST + 16) e3++;
        else if (i < 2*LRST + 24) e5++;
        else e7++;
      end
    chk(e2 == 0, "R2 line reset bits", e2, 0);
    chk(e3 == 0, conn ? "R3 connect code" : "R4 disconnect code", e3, 0);
    if (conn) begin
      chk(e5 == 0, "R5 second reset and idle", e5, 0);
      chk(e7 == 0, "R7 trailing idle", e7, 0);
      chk(req_seen && req_at == 2*LRST + 24, "R6 request position", req_at, 2*LRST + 24);
      chk(hdr_seen == 8'hA5, "R6 header", hdr_seen, 8'hA5);
      chk(!hold_bad, "R6 pins parked during read", hold_bad, 0);
    end else begin
      chk(!req_seen, "R4 no ID read", req_seen, 0);
      chk(busy_cyc == (LRST + 16) * 2 * HALF, "R10 busy length", busy_cyc, (LRST + 16) * 2 * HALF);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!swclk_o && swdio_o && !busy_o && !done_o && !xfer_req_o, "R1 reset outputs", swdio_o, 1);
    rst_ni = 1;
    @(negedge clk);
    chk(!swclk_o && swdio_o && !busy_o, "R1 idle after reset", busy_o, 0);

    for (int k = 0; k < NSCN; k++)
      run(SCN[k][8] ? 0 : 1, SCN[k][7:5], int'(SCN[k][4:1]), SCN[k][0]);

    // R9: both strobes together select connect
    run(2, 3'b001, 1, 1'b0);

    // R1: reset in the middle of a sequence
    @(negedge clk); connect_i = 1;
    @(negedge clk); connect_i = 0;
    repeat (100) @(negedge clk);
    rst_ni = 0;
    @(negedge clk);
    chk(!swclk_o && swdio_o && !busy_o && !xfer_req_o, "R1 mid-sequence reset", busy_o, 0);
    rst_ni = 1;
    repeat (5) @(negedge clk);
    chk(!busy_o && !done_o, "R1 stays idle", busy_o, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule